// File: doc/BRIEF.md
# I2C Target With Programmable Protocol Faults

This block sits on an I2C bus as a target device. In normal service it answers at a single 7-bit address: it acknowledges that address and the data bytes written to it, and it returns all-ones data on reads. It does not hold any storage behind the address. Its purpose is to test how a bus controller handles errors. When a command arrives on its control port, the block misbehaves in one of four chosen ways for a set span, then goes back to normal service.

The bus lines are open drain. The block samples SCL and SDA through a two-flop synchronizer. It only ever pulls a line low, using one pull enable per line; it never drives a line high. A command carries four things: the fault kind, a duration, a severity that scales the duration upward by powers of two, and a repeat count. Because of this, a test campaign can be replayed exactly. The block reports when a fault is running, when a command has been accepted and is still in progress, when a command was refused, and when the whole command has finished.

Top module: `i2cfi_top`

## Requirements
- R1: With no fault running, the block ACKs an address byte whose upper seven bits equal `own_addr_i` and NACKs any other address. After a write address it ACKs every data byte. After a read address it releases SDA for the data bits, so the controller reads 0xFF.
- R2: A START is SDA falling while SCL is high, and it begins a new address byte. A STOP is SDA rising while SCL is high, and it returns the block to idle. Both are judged on the synchronized line values.
- R3: After reset, both pull enables are low and `busy_o`, `fault_active_o`, `done_o` and `cmd_reject_o` are low. With no fault running, the only pull is the SDA pull for an acknowledge.
- R4: A fault starts only when `cmd_valid_i` is sampled high while no command is in progress. `busy_o` rises on that edge. Kind encoding: 0 NACK burst, 1 clock stretch, 2 stuck SDA, 3 address collision.
- R5: NACK burst. While the fault runs, every byte the block receives, address or data, is NACKed. The run ends once the span number of bytes have been received. After that, normal ACK behaviour returns.
- R6: Address collision. While the fault runs, every address byte is ACKed whether it matches or not, and the transfer that follows is treated as addressed. The run ends after the span number of address bytes.
- R7: Clock stretch. After acceptance, the block waits for the next SCL falling edge. It then holds SCL low for exactly span clock cycles and releases it.
- R8: Stuck SDA. From the edge after acceptance, SDA is pulled low for exactly span clock cycles, whatever SCL does.
- R9: The span equals the duration shifted left by the severity. A duration of zero counts as one.
- R10: A repeat count of R gives R+1 runs. Between runs there is one cycle in which `fault_active_o` is low while `busy_o` stays high. After the last run, `done_o` pulses for exactly one cycle and `busy_o` falls on the same edge.
- R11: A command that arrives while a command is in progress is refused. `cmd_reject_o` pulses on the next cycle, and the running fault carries on unchanged.
- R12: When `cmd_cancel_i` is sampled during a command, the block stops at once, releases both lines, lowers `busy_o` and pulses `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_i | input | 1 | SDA line level as seen on the bus |
| scl_pull_o | output | 1 | When high, pulls SCL low |
| sda_pull_o | output | 1 | When high, pulls SDA low |
| own_addr_i | input | ADDR_W | Configured target address |
| cmd_valid_i | input | 1 | Fault command strobe |
| cmd_kind_i | input | 2 | Fault kind (0 NACK, 1 stretch, 2 stuck, 3 collide) |
| cmd_duration_i | input | DUR_W | Base duration (cycles or bytes) |
| cmd_severity_i | input | SEV_W | Left-shift applied to the duration |
| cmd_repeat_i | input | REP_W | Extra runs after the first |
| cmd_cancel_i | input | 1 | Stops the command in progress |
| fault_active_o | output | 1 | A fault run is in progress |
| busy_o | output | 1 | A command is accepted and not yet finished |
| cmd_reject_o | output | 1 | One-cycle pulse: a command was refused |
| done_o | output | 1 | One-cycle pulse: the command has finished |

## Verification
An acknowledge appears on SDA three clock edges after the controller lowers SCL: two synchronizer stages, then the registered pull. The bench model therefore leaves at least two clocks between edges of the bus, and it judges each acknowledge only at the rising SCL edge of the ninth bit. `busy_o` and the fault pulls change on the edge that samples the command, while `cmd_reject_o` and `done_o` appear one edge after their cause. For this reason the bench counts pull, busy and active cycles at falling clock edges over windows that cover a whole command, rather than sampling single instants. Clock-stretch length is measured in the same way, as the number of cycles SCL is pulled, whenever the stretch begins.

// File: rtl/i2cfi_pkg.sv
package i2cfi_pkg;

  typedef enum logic [1:0] {
    FK_NACK    = 2'd0,
    FK_STRETCH = 2'd1,
    FK_STUCK   = 2'd2,
    FK_COLLIDE = 2'd3
  } fault_kind_e;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_RUN,
    CS_GAP
  } ctrl_state_e;

  typedef enum logic [2:0] {
    BP_IDLE,
    BP_ADDR,
    BP_WDATA,
    BP_ACK,
    BP_READ
  } bus_phase_e;

  // Acknowledge decision for a completed byte.
  function automatic logic ack_decide(input logic is_addr, input logic match,
                                      input logic nack_mode, input logic coll_mode);
    if (nack_mode) return 1'b0;
    if (is_addr)   return match | coll_mode;
    return 1'b1;
  endfunction

endpackage

// File: rtl/i2cfi_sync.sv
module i2cfi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  // Stages 0..STAGES-1 synchronize; the last stage holds the previous value.
  logic [STAGES:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], d};
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/i2cfi_byte_engine.sv
module i2cfi_byte_engine
  import i2cfi_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_p,
  input  logic              sda_s,
  input  logic              sda_p,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              nack_mode,
  input  logic              coll_mode,
  output logic              ack_drive,
  output logic              byte_evt,
  output logic              byte_is_addr,
  output logic              start_evt,
  output logic              stop_evt,
  output logic              scl_fall
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int BC_W   = $clog2(BYTE_W + 1);

  bus_phase_e        phase;
  logic [BYTE_W-1:0] shreg;
  logic [BC_W-1:0]   bitcnt;
  logic              addressed;
  logic              rw;
  logic              scl_rise;
  logic              addr_match;
  logic              ack_now;

  assign start_evt    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt     = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise     = scl_s & ~scl_p;
  assign scl_fall     = ~scl_s & scl_p;
  assign byte_is_addr = (phase == BP_ADDR);
  assign byte_evt     = ((phase == BP_ADDR) || (phase == BP_WDATA)) && scl_fall
                        && (bitcnt == BC_W'(BYTE_W));
  assign addr_match   = (shreg[BYTE_W-1:1] == own_addr);
  assign ack_now      = ack_decide(byte_is_addr, addr_match, nack_mode, coll_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= BP_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      addressed <= 1'b0;
      rw        <= 1'b0;
      ack_drive <= 1'b0;
    end else if (start_evt) begin
      phase     <= BP_ADDR;
      bitcnt    <= '0;
      addressed <= 1'b0;
      ack_drive <= 1'b0;
    end else if (stop_evt) begin
      phase     <= BP_IDLE;
      bitcnt    <= '0;
      addressed <= 1'b0;
      ack_drive <= 1'b0;
    end else begin
      case (phase)
        BP_ADDR, BP_WDATA: begin
          if (byte_evt) begin
            ack_drive <= ack_now;
            phase     <= BP_ACK;
            if (byte_is_addr) begin
              addressed <= ack_now;
              rw        <= shreg[0];
            end
          end else if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + BC_W'(1);
          end
        end
        BP_ACK: begin
          if (scl_fall) begin
            ack_drive <= 1'b0;
            bitcnt    <= '0;
            phase     <= !addressed ? BP_IDLE : (rw ? BP_READ : BP_WDATA);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cfi_fault_ctrl.sv
module i2cfi_fault_ctrl
  import i2cfi_pkg::*;
#(
  parameter int DUR_W = 16,
  parameter int SEV_W = 3,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [DUR_W-1:0] cmd_dur,
  input  logic [SEV_W-1:0] cmd_sev,
  input  logic [REP_W-1:0] cmd_rep,
  input  logic             cmd_cancel,
  input  logic             scl_fall,
  input  logic             byte_evt,
  input  logic             byte_is_addr,
  output logic             run,
  output logic             busy,
  output logic             done,
  output logic             reject,
  output logic             nack_mode,
  output logic             coll_mode,
  output logic             stuck_on,
  output logic             scl_hold
);
  localparam int SHIFT_MAX = (1 << SEV_W) - 1;
  localparam int CNT_W     = DUR_W + SHIFT_MAX;

  // Span of one run: duration (zero read as one) scaled by 2**severity.
  function automatic logic [CNT_W-1:0] span_of(input logic [DUR_W-1:0] d,
                                               input logic [SEV_W-1:0] s);
    logic [CNT_W-1:0] base;
    base = (d == '0) ? CNT_W'(1) : CNT_W'(d);
    return base << s;
  endfunction

  ctrl_state_e      state;
  fault_kind_e      kind_q;
  logic [DUR_W-1:0] dur_q;
  logic [SEV_W-1:0] sev_q;
  logic [REP_W-1:0] rep_left;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign run       = (state == CS_RUN);
  assign busy      = (state != CS_IDLE);
  assign nack_mode = run && (kind_q == FK_NACK);
  assign coll_mode = run && (kind_q == FK_COLLIDE);
  assign stuck_on  = run && (kind_q == FK_STUCK);

  always_comb begin
    case (kind_q)
      FK_STUCK:   tick = 1'b1;
      FK_STRETCH: tick = scl_hold;
      FK_NACK:    tick = byte_evt;
      default:    tick = byte_evt & byte_is_addr;
    endcase
    tick = tick & run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CS_IDLE;
      kind_q   <= FK_NACK;
      dur_q    <= '0;
      sev_q    <= '0;
      rep_left <= '0;
      cnt      <= '0;
      scl_hold <= 1'b0;
      done     <= 1'b0;
      reject   <= 1'b0;
    end else begin
      done   <= 1'b0;
      reject <= cmd_valid && (state != CS_IDLE);
      case (state)
        CS_IDLE: begin
          if (cmd_valid && !cmd_cancel) begin
            kind_q   <= fault_kind_e'(cmd_kind);
            dur_q    <= cmd_dur;
            sev_q    <= cmd_sev;
            rep_left <= cmd_rep;
            cnt      <= span_of(cmd_dur, cmd_sev);
            scl_hold <= 1'b0;
            state    <= CS_RUN;
          end
        end
        CS_RUN: begin
          if (cmd_cancel) begin
            state    <= CS_IDLE;
            scl_hold <= 1'b0;
            done     <= 1'b1;
          end else begin
            if (kind_q == FK_STRETCH && !scl_hold && scl_fall) scl_hold <= 1'b1;
            if (tick) begin
              if (cnt == CNT_W'(1)) begin
                scl_hold <= 1'b0;
                if (rep_left != '0) begin
                  rep_left <= rep_left - REP_W'(1);
                  cnt      <= span_of(dur_q, sev_q);
                  state    <= CS_GAP;
                end else begin
                  state <= CS_IDLE;
                  done  <= 1'b1;
                end
              end else begin
                cnt <= cnt - CNT_W'(1);
              end
            end
          end
        end
        default: begin
          if (cmd_cancel) begin
            state <= CS_IDLE;
            done  <= 1'b1;
          end else begin
            state <= CS_RUN;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2cfi_top.sv
module i2cfi_top
  import i2cfi_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DUR_W       = 16,
  parameter int SEV_W       = 3,
  parameter int REP_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_kind_i,
  input  logic [DUR_W-1:0]  cmd_duration_i,
  input  logic [SEV_W-1:0]  cmd_severity_i,
  input  logic [REP_W-1:0]  cmd_repeat_i,
  input  logic              cmd_cancel_i,
  output logic              fault_active_o,
  output logic              busy_o,
  output logic              cmd_reject_o,
  output logic              done_o
);
  logic [1:0] line_s;
  logic [1:0] line_p;
  logic       ack_drive;
  logic       byte_evt;
  logic       byte_is_addr;
  logic       start_evt;
  logic       stop_evt;
  logic       scl_fall;
  logic       nack_mode;
  logic       coll_mode;
  logic       stuck_on;
  logic       scl_hold;

  i2cfi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s), .q_prev(line_p)
  );

  i2cfi_byte_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_s(line_s[1]), .scl_p(line_p[1]), .sda_s(line_s[0]), .sda_p(line_p[0]),
    .own_addr(own_addr_i), .nack_mode(nack_mode), .coll_mode(coll_mode),
    .ack_drive(ack_drive), .byte_evt(byte_evt), .byte_is_addr(byte_is_addr),
    .start_evt(start_evt), .stop_evt(stop_evt), .scl_fall(scl_fall)
  );

  i2cfi_fault_ctrl #(.DUR_W(DUR_W), .SEV_W(SEV_W), .REP_W(REP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid_i), .cmd_kind(cmd_kind_i), .cmd_dur(cmd_duration_i),
    .cmd_sev(cmd_severity_i), .cmd_rep(cmd_repeat_i), .cmd_cancel(cmd_cancel_i),
    .scl_fall(scl_fall), .byte_evt(byte_evt), .byte_is_addr(byte_is_addr),
    .run(fault_active_o), .busy(busy_o), .done(done_o), .reject(cmd_reject_o),
    .nack_mode(nack_mode), .coll_mode(coll_mode), .stuck_on(stuck_on),
    .scl_hold(scl_hold)
  );

  // Open drain: only pull enables leave the block.
  assign sda_pull_o = stuck_on | ack_drive;
  assign scl_pull_o = scl_hold;
endmodule

// File: rtl/i2cfi_chk.sv
module i2cfi_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_cancel,
  input logic busy,
  input logic done,
  input logic reject,
  input logic scl_pull,
  input logic sda_pull,
  input logic byte_evt,
  input logic nack_mode
);
  // R4
  start_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R10
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> reject);

  // R12
  cancel_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cancel && busy) |=> (!busy && done && !scl_pull));

  // R7
  stretch_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> busy);

  // R5
  burst_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && nack_mode) |=> !sda_pull);
endmodule

bind i2cfi_top i2cfi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid_i), .cmd_cancel(cmd_cancel_i),
  .busy(busy_o), .done(done_o), .reject(cmd_reject_o), .scl_pull(scl_pull_o),
  .sda_pull(sda_pull_o), .byte_evt(byte_evt), .nack_mode(nack_mode)
);

// File: tb/test_i2cfi_top.sv
`timescale 1ns/1ps
module test_i2cfi_top;
  localparam int HALF = 10;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull_o, sda_pull_o;
  logic cmd_valid = 1'b0, cmd_cancel = 1'b0;
  logic [1:0] cmd_kind = '0;
  logic [15:0] cmd_dur = '0;
  logic [2:0] cmd_sev = '0;
  logic [7:0] cmd_rep = '0;
  logic fault_active_o, busy_o, cmd_reject_o, done_o;
  wire scl_line = scl_m & ~scl_pull_o;
  wire sda_line = sda_m & ~sda_pull_o;

  always #5 clk = ~clk;

  i2cfi_top i_i2cfi_top (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .own_addr_i(OWN),
    .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind), .cmd_duration_i(cmd_dur),
    .cmd_severity_i(cmd_sev), .cmd_repeat_i(cmd_rep), .cmd_cancel_i(cmd_cancel),
    .fault_active_o(fault_active_o), .busy_o(busy_o), .cmd_reject_o(cmd_reject_o),
    .done_o(done_o)
  );

  int total = 0, bad = 0;
  int n_scl = 0, n_sda = 0, n_busy = 0, n_act = 0, n_done = 0, n_rej = 0;
  bit finished = 0;

  typedef struct { bit v; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic check_eq(input string tag, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic expect_slot(input bit v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input int kind, input int dur, input int sev, input int rep);
    @(negedge clk);
    cmd_kind = 2'(kind); cmd_dur = 16'(dur); cmd_sev = 3'(sev); cmd_rep = 8'(rep);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1;
    wait_clk(HALF);
    sda_m = 1'b0;
    wait_clk(HALF);
    scl_m = 1'b0;
    wait_clk(2);
  endtask

  task automatic bus_bit(input bit b, output bit seen);
    sda_m = b;
    wait_clk(HALF);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(HALF);
    seen = sda_line;
    scl_m = 1'b0;
    wait_clk(2);
  endtask

  task automatic bus_byte(input logic [7:0] b, output logic [7:0] seen);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(b[i], s);
      seen[i] = s;
    end
    bus_bit(1'b1, s);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    wait_clk(HALF);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(HALF);
    sda_m = 1'b1;
    wait_clk(HALF);
  endtask

  // Activity counters sampled away from the active edge.
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (scl_pull_o)     n_scl++;
      if (sda_pull_o)     n_sda++;
      if (busy_o)         n_busy++;
      if (fault_active_o) n_act++;
      if (done_o)         n_done++;
      if (cmd_reject_o)   n_rej++;
    end
  end

  // Monitor: judges each ninth-bit SDA level against the scoreboard.
  initial begin : monitor
    logic ps, pd;
    int bits;
    exp_t e;
    ps = 1'b1; pd = 1'b1; bits = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (scl_line && ps && pd && !sda_line) bits = 0;
        else if (scl_line && !ps) begin
          bits++;
          if (bits == 9) begin
            bits = 0;
            if (exp_q.size() == 0) begin
              total++; bad++;
              $display("FAIL R1 unexpected ack slot actual=%0d expected=none", sda_line);
            end else begin
              e = exp_q.pop_front();
              check_eq(e.tag, sda_line, e.v);
            end
          end
        end
      end
      ps = scl_line; pd = sda_line;
    end
  end

  initial begin : watchdog
    wait_clk(150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    int s_scl, s_sda, s_busy, s_act, s_done, s_rej;
    wait_clk(5);
    // R3 reset state
    check_eq("R3 scl pull at reset", scl_pull_o, 0);
    check_eq("R3 sda pull at reset", sda_pull_o, 0);
    check_eq("R3 busy at reset", busy_o, 0);
    check_eq("R3 active/done/reject at reset", {fault_active_o, done_o, cmd_reject_o}, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 R2 normal write, foreign address, read
    s_busy = n_busy;
    expect_slot(0, "R1 R2 own write address ack");
    expect_slot(0, "R1 data byte 1 ack");
    expect_slot(0, "R1 data byte 2 ack");
    bus_start(); bus_byte({OWN, 1'b0}, rd); bus_byte(8'hC3, rd); bus_byte(8'h3C, rd); bus_stop();
    expect_slot(1, "R1 foreign address nack");
    bus_start(); bus_byte({7'h15, 1'b0}, rd); bus_stop();
    expect_slot(0, "R1 read address ack");
    expect_slot(1, "R1 read data slot released");
    bus_start(); bus_byte({OWN, 1'b1}, rd); bus_byte(8'hFF, rd); bus_stop();
    check_eq("R1 read data all ones", rd, 8'hFF);
    check_eq("R4 no busy without command", n_busy - s_busy, 0);
    check_eq("R3 no scl pull in normal service", n_scl, 0);

    // R5 NACK burst of 3 bytes
    s_done = n_done;
    issue(0, 3, 0, 0);
    check_eq("R4 busy after accept", busy_o, 1);
    for (int k = 0; k < 3; k++) begin
      expect_slot(1, "R5 burst nack of own address");
      bus_start(); bus_byte({OWN, 1'b0}, rd); bus_stop();
    end
    wait_clk(3);
    check_eq("R5 done after burst", n_done - s_done, 1);
    check_eq("R5 idle after burst", busy_o, 0);
    expect_slot(0, "R5 ack restored address");
    expect_slot(0, "R5 ack restored data");
    bus_start(); bus_byte({OWN, 1'b0}, rd); bus_byte(8'h11, rd); bus_stop();

    // R6 address collision, one address byte
    s_done = n_done;
    issue(3, 1, 0, 0);
    expect_slot(0, "R6 foreign address acked");
    expect_slot(0, "R6 data after collision acked");
    bus_start(); bus_byte({7'h33, 1'b0}, rd); bus_byte(8'h77, rd); bus_stop();
    wait_clk(3);
    check_eq("R6 done after one address", n_done - s_done, 1);
    expect_slot(1, "R6 foreign nack after collision");
    bus_start(); bus_byte({7'h33, 1'b0}, rd); bus_stop();

    // R7 R9 clock stretch, span 5<<2 = 20
    s_scl = n_scl; s_done = n_done;
    issue(1, 5, 2, 0);
    wait_clk(10);
    check_eq("R7 no stretch before scl fall", n_scl - s_scl, 0);
    expect_slot(0, "R7 address ack under stretch");
    expect_slot(0, "R7 data ack under stretch");
    bus_start(); bus_byte({OWN, 1'b0}, rd); bus_byte(8'h5A, rd); bus_stop();
    check_eq("R7 R9 stretch length", n_scl - s_scl, 20);
    check_eq("R7 done", n_done - s_done, 1);

    // R8 R10 stuck SDA span 4, two repeats, scl toggled
    s_sda = n_sda; s_busy = n_busy; s_act = n_act; s_done = n_done;
    issue(2, 4, 0, 2);
    for (int k = 0; k < 3; k++) begin
      scl_m = 1'b0; @(negedge clk); scl_m = 1'b1; @(negedge clk);
    end
    wait_clk(24);
    check_eq("R8 R10 stuck cycles over three runs", n_sda - s_sda, 12);
    check_eq("R10 busy cycles incl gaps", n_busy - s_busy, 14);
    check_eq("R10 active cycles", n_act - s_act, 12);
    check_eq("R10 single done", n_done - s_done, 1);
    check_eq("R10 idle after", busy_o, 0);

    // R9 zero duration and large severity
    s_sda = n_sda;
    issue(2, 0, 0, 0);
    wait_clk(5);
    check_eq("R9 zero duration is one", n_sda - s_sda, 1);
    s_sda = n_sda;
    issue(2, 3, 3, 0);
    wait_clk(30);
    check_eq("R9 duration 3 severity 3", n_sda - s_sda, 24);

    // R11 reject while busy, R12 cancel
    s_rej = n_rej; s_scl = n_scl; s_done = n_done;
    issue(2, 200, 0, 0);
    wait_clk(3);
    issue(1, 5, 0, 0);
    wait_clk(2);
    scl_m = 1'b0; wait_clk(4); scl_m = 1'b1; wait_clk(4);
    check_eq("R11 reject pulse", n_rej - s_rej, 1);
    check_eq("R11 still busy", busy_o, 1);
    check_eq("R11 stuck fault unchanged", sda_pull_o, 1);
    check_eq("R11 no stretch from refused command", n_scl - s_scl, 0);
    @(negedge clk); cmd_cancel = 1'b1;
    @(negedge clk); cmd_cancel = 1'b0;
    check_eq("R12 busy low after cancel", busy_o, 0);
    check_eq("R12 sda released after cancel", sda_pull_o, 0);
    check_eq("R12 done on cancel", n_done - s_done, 1);
    wait_clk(20);

    check_eq("R1 all ack slots seen", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule